// File: doc/BRIEF.md
# Premodulated Waveform Word Streamer

The streamer turns a sequence of run requests into a continuous serial bitstream. Each request asks for either a run of N words at one fixed level code, or a run of pixel words taken from a line memory. Every output word is a 32-bit entry read from an external premodulated waveform table. The table address combines a phase pointer with a 4-bit code. The phase pointer moves forward by one phase step after every word, so consecutive words carry on the carrier pattern from where the last one stopped. A serializer then shifts each word out, most significant bit first, one bit per clock.

The pointer is folded back into the table only at fixed points. In level runs that point is after each pair of words. In pixel runs it is after each group of four words. A leading odd word in a level run moves the pointer without any fold. When the pointer is folded, the amount by which it passed the table end is kept. The external table therefore holds `SLACK` extra phase rows beyond `PHASES`, and these cover the overshoot. In pixel mode the block reads 16-bit memory words from a double-buffered line memory, one frame per half. Each memory word is split into four codes.

Top module: `premod_word_streamer`

## Requirements
- R1: Out of reset `sdata`, `bit_valid` and `underflow` are 0 and `req_ready` is 1. The phase pointer starts at phase 0, so the first word uses phase row 0.
- R2: In a level run, every word is read from table address `{phase, level}`, with the phase in the upper bits and the 4-bit level in the low 4 bits. The phase rises by one after each word.
- R3: In a level run, the fold check is made after the second word of each pair. If the phase is at least `PHASES`, `PHASES` is subtracted from it, which keeps any overshoot.
- R4: When the count of a level run is odd, its first word advances the phase with no fold check. The remaining count/2 pairs then follow R3.
- R5: In a pixel run, each 16-bit memory word supplies four table codes, starting with bits [3:0] and ending with bits [15:12]. The phase rises by one per word. The fold check of R3 is made after each group of four words.
- R6: A pixel run with count C reads memory address `{odd_frame, row, column}` for columns 0 to C-1 in order. The most significant bit of that address is the frame-parity bit.
- R7: Each word is sent most significant bit first, one bit per clock, while `bit_valid` is 1. When the next word is already staged, it starts on the clock right after the last bit of the previous word.
- R8: If no word is staged when the last bit of a word has been sent, `underflow` is high for exactly one cycle. In that same cycle the line goes low and `bit_valid` falls.
- R9: A request with count 0 is accepted and produces no words. `req_ready` is back high on the next cycle.
- R10: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after a nonzero request is accepted until that run's last word has been fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Run request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_count | input | 8 | Word count (level run) or memory-word count (pixel run) |
| req_level | input | 4 | Level code for a level run |
| req_pixel | input | 1 | 1 selects pixel run |
| req_row | input | 3 | Line index for a pixel run |
| req_odd_frame | input | 1 | Frame parity selecting the memory half |
| tbl_addr | output | 8 | Waveform table address {phase, code} |
| tbl_data | input | 32 | Table entry at `tbl_addr`, combinational |
| pix_addr | output | 6 | Line memory address {odd_frame, row, column} |
| pix_data | input | 16 | Line memory word at `pix_addr`, combinational |
| sdata | output | 1 | Serial output line |
| bit_valid | output | 1 | `sdata` carries a word bit this cycle |
| underflow | output | 1 | One-cycle pulse when the serializer ran dry |

## Verification
The scoreboard drives one unbroken chain of runs. The chain contains even and odd level counts, a single-word run, a long run that folds the phase several times, and a zero-count run. It also contains pixel runs from both frame halves and from different rows. Even counts against odd counts tell whether the fold is skipped after the lone leading word. A single word that leaves the phase at 12 (with `PHASES`=12), followed by a pair, shows whether the overshoot survives the fold or is reset to zero. The pixel runs show whether the nibble order, the frame bit and the row are right. Letting the stream drain twice shows that the underflow pulse happens once per gap and never in the middle of a word.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        G_IDLE,
        G_SOLO,
        G_PAIR_A,
        G_PAIR_B,
        G_PIX
    } gen_state_t;

    typedef enum logic {
        S_IDLE,
        S_SHIFT
    } ser_state_t;

endpackage

// File: rtl/pms_phase_gen.sv
module pms_phase_gen
    import pms_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int SLACK  = 4,
    parameter int CODE_W = 4,
    parameter int CNT_W  = 8,
    parameter int ROWS   = 8,
    parameter int COLS   = 4,
    parameter int PIX_W  = 16,
    localparam int TPH    = PHASES + SLACK,
    localparam int PH_W   = $clog2(TPH),
    localparam int PTR_W  = $clog2(TPH + 1),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int NIBS   = PIX_W / CODE_W,
    localparam int NIB_W  = $clog2(NIBS),
    localparam int TA_W   = PH_W + CODE_W,
    localparam int PA_W   = 1 + ROW_W + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CNT_W-1:0] req_count,
    input  logic [CODE_W-1:0] req_level,
    input  logic             req_pixel,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_odd_frame,
    output logic [TA_W-1:0]  tbl_addr,
    output logic [PA_W-1:0]  pix_addr,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             word_ready,
    output logic             word_valid
);

    gen_state_t        st, st_n;
    logic [PTR_W-1:0]  ph, ph_n;
    logic [CODE_W-1:0] lvl, lvl_n;
    logic [CNT_W-1:0]  left, left_n;
    logic [COL_W-1:0]  col, col_n;
    logic [NIB_W-1:0]  nib, nib_n;
    logic [ROW_W-1:0]  row, row_n;
    logic              frm, frm_n;
    logic [CODE_W-1:0] code;

    function automatic logic [PTR_W-1:0] fold(input logic [PTR_W-1:0] p);
        if (p >= PTR_W'(PHASES))
            return p - PTR_W'(PHASES);
        return p;
    endfunction

    // next-state and pointer stepping
    always_comb begin
        st_n   = st;
        ph_n   = ph;
        lvl_n  = lvl;
        left_n = left;
        col_n  = col;
        nib_n  = nib;
        row_n  = row;
        frm_n  = frm;
        unique case (st)
            G_IDLE: begin
                if (req_valid && req_count != '0) begin
                    lvl_n = req_level;
                    row_n = req_row;
                    frm_n = req_odd_frame;
                    col_n = '0;
                    nib_n = '0;
                    if (req_pixel) begin
                        left_n = req_count;
                        st_n   = G_PIX;
                    end else begin
                        left_n = req_count >> 1;
                        st_n   = req_count[0] ? G_SOLO : G_PAIR_A;
                    end
                end
            end
            G_SOLO: begin
                if (word_ready) begin
                    ph_n = ph + PTR_W'(1);
                    st_n = (left == '0) ? G_IDLE : G_PAIR_A;
                end
            end
            G_PAIR_A: begin
                if (word_ready) begin
                    ph_n = ph + PTR_W'(1);
                    st_n = G_PAIR_B;
                end
            end
            G_PAIR_B: begin
                if (word_ready) begin
                    ph_n   = fold(ph + PTR_W'(1));
                    left_n = left - CNT_W'(1);
                    st_n   = (left == CNT_W'(1)) ? G_IDLE : G_PAIR_A;
                end
            end
            G_PIX: begin
                if (word_ready) begin
                    nib_n = nib + NIB_W'(1);
                    if (nib == NIB_W'(NIBS - 1)) begin
                        ph_n   = fold(ph + PTR_W'(1));
                        col_n  = col + COL_W'(1);
                        left_n = left - CNT_W'(1);
                        if (left == CNT_W'(1))
                            st_n = G_IDLE;
                    end else begin
                        ph_n = ph + PTR_W'(1);
                    end
                end
            end
            default: st_n = G_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= G_IDLE;
            ph   <= '0;
            lvl  <= '0;
            left <= '0;
            col  <= '0;
            nib  <= '0;
            row  <= '0;
            frm  <= 1'b0;
        end else begin
            st   <= st_n;
            ph   <= ph_n;
            lvl  <= lvl_n;
            left <= left_n;
            col  <= col_n;
            nib  <= nib_n;
            row  <= row_n;
            frm  <= frm_n;
        end
    end

    // outputs
    always_comb begin
        code = lvl;
        if (st == G_PIX) begin
            for (int k = 0; k < NIBS; k++)
                if (nib == NIB_W'(k))
                    code = pix_data[k*CODE_W +: CODE_W];
        end
        tbl_addr   = {ph[PH_W-1:0], code};
        pix_addr   = {frm, row, col};
        req_ready  = (st == G_IDLE);
        word_valid = (st != G_IDLE) && word_ready;
    end

    assert_pair_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == G_PAIR_B && word_valid) |=> (ph < PTR_W'(PHASES)));

    assert_ptr_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (ph < PTR_W'(TPH)));

    assert_solo_nowrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == G_SOLO && word_valid) |=> (ph == $past(ph) + PTR_W'(1)));

    assert_group_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == G_PIX && word_valid && nib == NIB_W'(NIBS - 1)) |=> (ph < PTR_W'(PHASES)));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_count != '0) |=> !req_ready);

endmodule

// File: rtl/pms_serializer.sv
module pms_serializer
    import pms_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int BC_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              sdata,
    output logic              bit_valid,
    output logic              underflow
);

    ser_state_t        st, st_n;
    logic [WORD_W-1:0] hold_q;
    logic              hold_full;
    logic [WORD_W-1:0] shreg;
    logic [BC_W-1:0]   bcnt;
    logic              last_bit;
    logic              load;

    // next-state
    always_comb begin
        last_bit = (bcnt == BC_W'(WORD_W - 1));
        load     = 1'b0;
        st_n     = st;
        unique case (st)
            S_IDLE: begin
                if (hold_full) begin
                    load = 1'b1;
                    st_n = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (last_bit) begin
                    if (hold_full)
                        load = 1'b1;
                    else
                        st_n = S_IDLE;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shreg     <= '0;
            bcnt      <= '0;
            underflow <= 1'b0;
        end else begin
            st        <= st_n;
            underflow <= (st == S_SHIFT) && last_bit && !hold_full;
            if (load) begin
                shreg     <= hold_q;
                bcnt      <= '0;
                hold_full <= 1'b0;
            end else begin
                if (in_valid && !hold_full) begin
                    hold_q    <= in_word;
                    hold_full <= 1'b1;
                end
                if (st == S_SHIFT) begin
                    shreg <= (st_n == S_IDLE) ? '0 : {shreg[WORD_W-2:0], 1'b0};
                    bcnt  <= bcnt + BC_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = !hold_full;
        bit_valid = (st == S_SHIFT);
        sdata     = (st == S_SHIFT) ? shreg[WORD_W-1] : 1'b0;
    end

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !sdata);

    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT && last_bit && hold_full) |=> (bit_valid && bcnt == '0));

    assert_underflow_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!bit_valid && !sdata));

    assert_underflow_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);

endmodule

// File: rtl/premod_word_streamer.sv
module premod_word_streamer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_count,
    input  logic [3:0]  req_level,
    input  logic        req_pixel,
    input  logic [2:0]  req_row,
    input  logic        req_odd_frame,
    output logic [7:0]  tbl_addr,
    input  logic [31:0] tbl_data,
    output logic [5:0]  pix_addr,
    input  logic [15:0] pix_data,
    output logic        sdata,
    output logic        bit_valid,
    output logic        underflow
);

    localparam int PHASES = 12;
    localparam int SLACK  = 4;
    localparam int WORD_W = 32;

    logic word_ready;
    logic word_valid;

    pms_phase_gen #(
        .PHASES (PHASES),
        .SLACK  (SLACK),
        .CODE_W (4),
        .CNT_W  (8),
        .ROWS   (8),
        .COLS   (4),
        .PIX_W  (16)
    ) u_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_count     (req_count),
        .req_level     (req_level),
        .req_pixel     (req_pixel),
        .req_row       (req_row),
        .req_odd_frame (req_odd_frame),
        .tbl_addr      (tbl_addr),
        .pix_addr      (pix_addr),
        .pix_data      (pix_data),
        .word_ready    (word_ready),
        .word_valid    (word_valid)
    );

    pms_serializer #(
        .WORD_W (WORD_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (word_valid),
        .in_word   (tbl_data),
        .in_ready  (word_ready),
        .sdata     (sdata),
        .bit_valid (bit_valid),
        .underflow (underflow)
    );

endmodule

// File: tb/premod_word_streamer_test.sv
module premod_word_streamer_test;

    localparam int PHASES = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_count;
    logic [3:0]  req_level;
    logic        req_pixel;
    logic [2:0]  req_row;
    logic        req_odd_frame;
    logic [7:0]  tbl_addr;
    logic [31:0] tbl_data;
    logic [5:0]  pix_addr;
    logic [15:0] pix_data;
    logic        sdata;
    logic        bit_valid;
    logic        underflow;

    always #2 clk = ~clk;

    premod_word_streamer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_count(req_count), .req_level(req_level), .req_pixel(req_pixel),
        .req_row(req_row), .req_odd_frame(req_odd_frame), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .pix_addr(pix_addr), .pix_data(pix_data),
        .sdata(sdata), .bit_valid(bit_valid), .underflow(underflow)
    );

    function automatic logic [31:0] tfun(input logic [7:0] a);
        return ((32'(a) + 32'd1) * 32'h9E3779B1) ^ {a, 24'h5A3C96};
    endfunction

    function automatic logic [15:0] pfun(input logic [5:0] a);
        return 16'h3C5A ^ (16'(a) * 16'h0B6D) ^ {a[3:0], 12'h000};
    endfunction

    always_comb tbl_data = tfun(tbl_addr);
    always_comb pix_data = pfun(pix_addr);

    logic [31:0] expq[$];
    string       tagq[$];
    int          errors = 0;
    int          checks = 0;
    int          ph_m = 0;
    int          uf_cnt = 0;
    int          nb = 0;
    logic [31:0] shw = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input int code, input string tag);
        expq.push_back(tfun(8'((ph_m << 4) | code)));
        tagq.push_back(tag);
        ph_m++;
    endtask

    task automatic fold_m;
        if (ph_m >= PHASES) ph_m -= PHASES;
    endtask

    // driver: pushes expected words, then hands the request over
    task automatic send(input int cnt, input int lvl, input bit pix, input int row, input bit frm, input string tag);
        if (!pix) begin
            if (cnt % 2 == 1) push_word(lvl, tag);
            for (int p = 0; p < cnt / 2; p++) begin
                push_word(lvl, tag);
                push_word(lvl, tag);
                fold_m();
            end
        end else begin
            for (int w = 0; w < cnt; w++) begin
                logic [15:0] d;
                d = pfun({frm, 3'(row), 2'(w)});
                for (int n = 0; n < 4; n++) push_word(int'((d >> (4 * n)) & 16'hF), tag);
                fold_m();
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_count     = 8'(cnt);
        req_level     = 4'(lvl);
        req_pixel     = pix;
        req_row       = 3'(row);
        req_odd_frame = frm;
        req_valid     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (cnt == 0)
            check(req_ready == 1'b1, "R9 ready after empty run", 32'(req_ready), 32'd1);
        else
            check(req_ready == 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
    endtask

    // monitor: assemble serial words and compare against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                shw = {shw[30:0], sdata};
                nb++;
                if (nb == 32) begin
                    nb = 0;
                    if (expq.size() == 0) begin
                        check(1'b0, "R7 unexpected word", shw, 32'h0);
                    end else begin
                        logic [31:0] e;
                        string t;
                        e = expq.pop_front();
                        t = tagq.pop_front();
                        check(shw == e, t, shw, e);
                    end
                end
            end
            if (underflow) begin
                uf_cnt++;
                check(nb == 0 && !sdata, "R8 underflow on word boundary, line low", 32'(nb), 32'd0);
            end
        end
    end

    task automatic drain;
        while (expq.size() != 0 || bit_valid) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_count = '0;
        req_level = '0;
        req_pixel = 1'b0;
        req_row = '0;
        req_odd_frame = 1'b0;
        repeat (3) @(negedge clk);
        check(sdata == 1'b0, "R1 line low in reset", 32'(sdata), 32'd0);
        check(bit_valid == 1'b0, "R1 no bits in reset", 32'(bit_valid), 32'd0);
        check(underflow == 1'b0, "R1 no underflow in reset", 32'(underflow), 32'd0);
        check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;

        send(6, 3, 1'b0, 0, 1'b0, "R1 R2 even run from phase 0");
        send(7, 9, 1'b0, 0, 1'b0, "R4 odd run");
        send(1, 15, 1'b0, 0, 1'b0, "R4 single word");
        send(20, 0, 1'b0, 0, 1'b0, "R3 long run folding");
        send(0, 5, 1'b0, 0, 1'b0, "R9 empty run");
        send(4, 0, 1'b1, 5, 1'b0, "R5 R6 pixels even frame");
        send(3, 0, 1'b1, 2, 1'b1, "R5 R6 pixels odd frame");
        send(9, 7, 1'b0, 0, 1'b0, "R4 odd run ending at phase 11");
        send(1, 10, 1'b0, 0, 1'b0, "R3 lone word to phase 12");
        send(2, 6, 1'b0, 0, 1'b0, "R3 overshoot kept on fold");
        drain();
        check(uf_cnt == 1, "R8 one underflow after first stream", 32'(uf_cnt), 32'd1);
        check(sdata == 1'b0 && bit_valid == 1'b0, "R8 line low when drained", 32'(sdata), 32'd0);

        send(1, 2, 1'b0, 0, 1'b0, "R7 restart after underflow");
        send(2, 12, 1'b0, 0, 1'b0, "R7 back to back pair");
        drain();
        check(uf_cnt == 2, "R8 one underflow per gap", 32'(uf_cnt), 32'd2);
        check(expq.size() == 0, "R7 all words delivered", 32'(expq.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule